// File: doc/BRIEF.md
# Serial Engine Status and Interrupt Flags

This block collects status and error events from a FIFO-based serial controller and turns them into three readable flag registers and one active-high, level-sensitive interrupt line. Single-cycle event pulses from the data path set sticky flags. Software clears a flag by writing a 1 to its bit position, which usually means writing back the value it has just read. Bits written as 0 are left as they are.

There are three flag groups. Each group is cleared on its own. The first group holds the FIFO service requests and the maximum-count-done indications, and it always raises the interrupt. The second group holds the transfer overrun and underrun errors. The third group holds the serial-clock overrun and underrun errors. Each error group has an enable register that uses the same bit positions. An error flag always latches, but it reaches the interrupt only when its enable bit is set. The operational register also shows the live FIFO full and not-empty levels. Those bits follow their inputs and cannot be written.

The register port is a plain one-cycle write strobe with a select code. It has no handshake, so the block accepts every write. All registers are always visible on output buses.

Top module: `se_status_irq`

## Requirements
- R1: After reset, every flag register and enable register reads zero and `irq` is low.
- R2: A 1 on `ev_op[3:0]` sets the sticky operational bits 11..8 (input max done, output max done, input service, output service). A set bit stays set until it is cleared.
- R3: Operational bits 7..4 show `fifo_live[3:0]` (input full, output full, input not-empty, output not-empty) in the same cycle. A write to the operational register does not change them.
- R4: A 1 on `ev_xfer[3:0]` sets the sticky transfer-error bits 5..2 (output overrun, input underrun, output underrun, input overrun).
- R5: A 1 on `ev_clk[1:0]` sets the sticky clock-error bits 1..0 (clock overrun, clock underrun).
- R6: A write with `wr_sel` set to 0 (operational), 1 (transfer error) or 3 (clock error) clears each sticky bit of that register whose `wr_data` bit is 1. Bits written 0 keep their value, and the other registers do not change.
- R7: When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: A write with `wr_sel` 2 loads the transfer-error enable bits 5..2, and a write with `wr_sel` 4 loads the clock-error enable bits 1..0. All other bit positions of every register read zero.
- R9: `irq` is high exactly when an operational sticky bit is set, or an enabled transfer error is set, or an enabled clock error is set. It changes in the same cycle as the flags.
- R10: A disabled error flag still latches but does not raise `irq`. `irq` stays high until the last contributing flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 3 | Register select: 0 op, 1 xfer err, 2 xfer enable, 3 clk err, 4 clk enable |
| wr_data | input | REG_W | Write data |
| ev_op | input | 4 | Operational event pulses for bits 11..8 |
| fifo_live | input | 4 | Live FIFO levels shown in bits 7..4 |
| ev_xfer | input | 4 | Transfer error pulses for bits 5..2 |
| ev_clk | input | 2 | Clock error pulses for bits 1..0 |
| op_flags | output | REG_W | Operational register |
| xfer_err | output | REG_W | Transfer-error register |
| xfer_en | output | REG_W | Transfer-error enable register |
| clk_err | output | REG_W | Clock-error register |
| clk_en | output | REG_W | Clock-error enable register |
| irq | output | 1 | Level-high interrupt |

## Verification
The assertions check on every cycle that each event pulse sets its bits, that a write-one clear on a quiet bit takes effect, that untouched sticky bits hold their value, that unused bit positions stay zero, and that `irq` equals the masked OR of the three groups. Only the bench scenarios show the ordered behaviour. These include a bit that survives when set and clear collide, a masked error that latches silently and then raises `irq` once its enable is written, and `irq` that stays high through a partial clear and drops only on the last one. A reference model is compared against every output on every clock.

// File: rtl/sestat_pkg.sv
package sestat_pkg;
  localparam int OP_STICKY_N   = 4;
  localparam int OP_STICKY_LSB = 8;
  localparam int OP_LIVE_N     = 4;
  localparam int OP_LIVE_LSB   = 4;
  localparam int XERR_N        = 4;
  localparam int XERR_LSB      = 2;
  localparam int CERR_N        = 2;
  localparam int CERR_LSB      = 0;
  localparam int MIN_REG_W     = OP_STICKY_LSB + OP_STICKY_N;

  typedef enum logic [2:0] {
    SEL_OP   = 3'd0,
    SEL_XERR = 3'd1,
    SEL_XEN  = 3'd2,
    SEL_CERR = 3'd3,
    SEL_CEN  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/sestat_flag_bank.sv
module sestat_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o[b] <= 1'b0;
      else if (set_i[b]) flag_o[b] <= 1'b1;   // set has priority over clear
      else if (clr_i[b]) flag_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/sestat_en_reg.sv
module sestat_en_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/sestat_irq_merge.sv
module sestat_irq_merge #(
  parameter int NS = 4,
  parameter int NX = 4,
  parameter int NC = 2
) (
  input  logic [NS-1:0] svc_i,
  input  logic [NX-1:0] xerr_i,
  input  logic [NX-1:0] xen_i,
  input  logic [NC-1:0] cerr_i,
  input  logic [NC-1:0] cen_i,
  output logic          irq_o
);
  logic svc_any, x_any, c_any;
  always_comb begin
    svc_any = |svc_i;
    x_any   = |(xerr_i & xen_i);
    c_any   = |(cerr_i & cen_i);
    irq_o   = svc_any | x_any | c_any;
  end
endmodule

// File: rtl/se_status_irq.sv
module se_status_irq
  import sestat_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [3:0]       ev_op,
  input  logic [3:0]       fifo_live,
  input  logic [3:0]       ev_xfer,
  input  logic [1:0]       ev_clk,
  output logic [REG_W-1:0] op_flags,
  output logic [REG_W-1:0] xfer_err,
  output logic [REG_W-1:0] xfer_en,
  output logic [REG_W-1:0] clk_err,
  output logic [REG_W-1:0] clk_en,
  output logic             irq
);
  localparam int OP_HI = OP_STICKY_LSB + OP_STICKY_N - 1;
  localparam int LV_HI = OP_LIVE_LSB + OP_LIVE_N - 1;
  localparam int XE_HI = XERR_LSB + XERR_N - 1;
  localparam int CE_HI = CERR_LSB + CERR_N - 1;

  logic hit_op, hit_xerr, hit_xen, hit_cerr, hit_cen;
  logic [OP_STICKY_N-1:0] op_q, op_clr;
  logic [XERR_N-1:0]      xe_q, xe_clr, xen_q;
  logic [CERR_N-1:0]      ce_q, ce_clr, cen_q;

  always_comb begin
    hit_op   = wr_en && (wr_sel == SEL_OP);
    hit_xerr = wr_en && (wr_sel == SEL_XERR);
    hit_xen  = wr_en && (wr_sel == SEL_XEN);
    hit_cerr = wr_en && (wr_sel == SEL_CERR);
    hit_cen  = wr_en && (wr_sel == SEL_CEN);
    op_clr   = hit_op   ? wr_data[OP_HI:OP_STICKY_LSB] : '0;
    xe_clr   = hit_xerr ? wr_data[XE_HI:XERR_LSB]      : '0;
    ce_clr   = hit_cerr ? wr_data[CE_HI:CERR_LSB]      : '0;
  end

  sestat_flag_bank #(.N(OP_STICKY_N)) u_op_bank (
    .clk(clk), .rst_n(rst_n), .set_i(ev_op), .clr_i(op_clr), .flag_o(op_q));
  sestat_flag_bank #(.N(XERR_N)) u_xerr_bank (
    .clk(clk), .rst_n(rst_n), .set_i(ev_xfer), .clr_i(xe_clr), .flag_o(xe_q));
  sestat_flag_bank #(.N(CERR_N)) u_cerr_bank (
    .clk(clk), .rst_n(rst_n), .set_i(ev_clk), .clr_i(ce_clr), .flag_o(ce_q));

  sestat_en_reg #(.N(XERR_N)) u_xen (
    .clk(clk), .rst_n(rst_n), .we_i(hit_xen),
    .d_i(wr_data[XE_HI:XERR_LSB]), .q_o(xen_q));
  sestat_en_reg #(.N(CERR_N)) u_cen (
    .clk(clk), .rst_n(rst_n), .we_i(hit_cen),
    .d_i(wr_data[CE_HI:CERR_LSB]), .q_o(cen_q));

  sestat_irq_merge #(.NS(OP_STICKY_N), .NX(XERR_N), .NC(CERR_N)) u_irq (
    .svc_i(op_q), .xerr_i(xe_q), .xen_i(xen_q),
    .cerr_i(ce_q), .cen_i(cen_q), .irq_o(irq));

  always_comb begin
    op_flags = '0;
    op_flags[OP_HI:OP_STICKY_LSB] = op_q;
    op_flags[LV_HI:OP_LIVE_LSB]   = fifo_live;
    xfer_err = '0;
    xfer_err[XE_HI:XERR_LSB] = xe_q;
    xfer_en  = '0;
    xfer_en[XE_HI:XERR_LSB]  = xen_q;
    clk_err  = '0;
    clk_err[CE_HI:CERR_LSB]  = ce_q;
    clk_en   = '0;
    clk_en[CE_HI:CERR_LSB]   = cen_q;
  end
endmodule

// File: rtl/se_status_irq_chk.sv
module se_status_irq_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic [3:0]       ev_op,
  input logic [3:0]       ev_xfer,
  input logic [1:0]       ev_clk,
  input logic [REG_W-1:0] op_flags,
  input logic [REG_W-1:0] xfer_err,
  input logic [REG_W-1:0] xfer_en,
  input logic [REG_W-1:0] clk_err,
  input logic [REG_W-1:0] clk_en,
  input logic             irq
);
  p_op_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_op != 4'd0) |=> ((op_flags[11:8] & $past(ev_op)) == $past(ev_op)));

  p_xerr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xfer != 4'd0) |=> ((xfer_err[5:2] & $past(ev_xfer)) == $past(ev_xfer)));

  p_cerr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clk != 2'd0) |=> ((clk_err[1:0] & $past(ev_clk)) == $past(ev_clk)));

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && ev_op == 4'd0)
      |=> ((op_flags[11:8] & $past(wr_data[11:8])) == 4'd0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_sel == 3'd0) && ev_op == 4'd0)
      |=> (op_flags[11:8] == $past(op_flags[11:8])));

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en[1:0] == 2'd0) && (xfer_en[REG_W-1:6] == '0) &&
    (clk_en[REG_W-1:2] == '0) && (clk_err[REG_W-1:2] == '0) &&
    (op_flags[REG_W-1:12] == '0));

  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((|op_flags[11:8]) || (|(xfer_err[5:2] & xfer_en[5:2])) ||
            (|(clk_err[1:0] & clk_en[1:0]))));
endmodule

bind se_status_irq se_status_irq_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ev_op(ev_op), .ev_xfer(ev_xfer), .ev_clk(ev_clk),
  .op_flags(op_flags), .xfer_err(xfer_err), .xfer_en(xfer_en),
  .clk_err(clk_err), .clk_en(clk_en), .irq(irq));

// File: tb/se_status_irq_tb_top.sv
`timescale 1ns/1ps
module se_status_irq_tb_top;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [W-1:0] wr_data = '0;
  logic [3:0] ev_op = 4'd0, fifo_live = 4'd0, ev_xfer = 4'd0;
  logic [1:0] ev_clk = 2'd0;
  logic [W-1:0] op_flags, xfer_err, xfer_en, clk_err, clk_en;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  se_status_irq #(.REG_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ev_op(ev_op), .fifo_live(fifo_live), .ev_xfer(ev_xfer), .ev_clk(ev_clk),
    .op_flags(op_flags), .xfer_err(xfer_err), .xfer_en(xfer_en),
    .clk_err(clk_err), .clk_en(clk_en), .irq(irq));

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: registers as plain integers, updated from the requirements.
  int m_op, m_xe, m_xen, m_ce, m_cen;
  always @(posedge clk) begin
    int exp_op, exp_irq;
    if (!rst_n) begin
      m_op = 0; m_xe = 0; m_xen = 0; m_ce = 0; m_cen = 0;
    end else begin
      if (wr_en && wr_sel == 3'd0) m_op = m_op & ~(int'(wr_data) & 32'hF00);
      if (wr_en && wr_sel == 3'd1) m_xe = m_xe & ~(int'(wr_data) & 32'h3C);
      if (wr_en && wr_sel == 3'd3) m_ce = m_ce & ~(int'(wr_data) & 32'h3);
      if (wr_en && wr_sel == 3'd2) m_xen = int'(wr_data) & 32'h3C;
      if (wr_en && wr_sel == 3'd4) m_cen = int'(wr_data) & 32'h3;
      m_op = m_op | (int'(ev_op) << 8);
      m_xe = m_xe | (int'(ev_xfer) << 2);
      m_ce = m_ce | int'(ev_clk);
    end
    #5;
    if (rst_n) begin
      exp_op = m_op | (int'(fifo_live) << 4);
      exp_irq = ((m_op != 0) || ((m_xe & m_xen) != 0) || ((m_ce & m_cen) != 0)) ? 1 : 0;
      check("R2 op sticky", op_flags & 32'hF00, m_op);
      check("R3 op live", op_flags & 32'hF0, exp_op & 32'hF0);
      check("R4 xfer err", xfer_err, m_xe);
      check("R5 clk err", clk_err, m_ce);
      check("R8 enables", {xfer_en, clk_en}, {m_xen, m_cen});
      check("R9 irq", irq, exp_irq);
    end
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 0; wr_data = '0; ev_op = 0; ev_xfer = 0; ev_clk = 0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    tick();
    idle();
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1: reset state
    check("R1 op", op_flags, 0);
    check("R1 xerr", xfer_err, 0);
    check("R1 irq", irq, 0);
    @(negedge clk); rst_n = 1;
    tick();

    // R2: op events set sticky bits; R9 irq
    @(negedge clk); ev_op = 4'b1010;
    tick();
    idle();
    tick();
    check("R2 op bits held", op_flags[11:8], 4'b1010);
    check("R9 irq from op", irq, 1);

    // R3: live bits mirror input and ignore writes
    @(negedge clk); fifo_live = 4'b0110;
    #1 check("R3 live same cycle", op_flags[7:4], 4'b0110);
    wr(3'd0, 32'h0F0);
    check("R3 live after write", op_flags[7:4], 4'b0110);
    check("R3 sticky untouched", op_flags[11:8], 4'b1010);

    // R6/R10: partial clear keeps irq, last clear drops it
    wr(3'd0, 32'h800);
    check("R6 partial clear", op_flags[11:8], 4'b0010);
    check("R10 irq held", irq, 1);
    wr(3'd0, 32'h200);
    check("R6 full clear", op_flags[11:8], 4'b0000);
    check("R10 irq dropped", irq, 0);

    // R4/R10: masked transfer error latches silently
    @(negedge clk); ev_xfer = 4'b1001;
    tick();
    idle();
    check("R4 xfer latched", xfer_err, 32'h24);
    check("R10 masked no irq", irq, 0);
    wr(3'd2, 32'h20);
    check("R9 enabled irq", irq, 1);
    wr(3'd1, 32'h20);
    check("R6 xerr clear", xfer_err, 32'h04);
    check("R10 irq after clear", irq, 0);

    // R8: enable field width
    wr(3'd2, 32'hFFFF_FFFF);
    check("R8 xen mask", xfer_en, 32'h3C);
    wr(3'd1, 32'h04);
    wr(3'd4, 32'hFFFF_FFFF);
    check("R8 cen mask", clk_en, 32'h3);

    // R5: clock error
    @(negedge clk); ev_clk = 2'b01;
    tick();
    idle();
    check("R5 clk err", clk_err, 32'h1);
    check("R9 clk irq", irq, 1);

    // R7: set wins over clear
    @(negedge clk); ev_clk = 2'b10; wr_en = 1; wr_sel = 3'd3; wr_data = 32'h3;
    tick();
    idle();
    check("R7 set wins", clk_err, 32'h2);
    wr(3'd3, 32'h2);
    check("R6 clk clear", clk_err, 0);
    check("R1 R9 irq idle", irq, 0);

    repeat (3) tick();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule